// File: doc/BRIEF.md
# Page-Mapped Flash Translation Controller

This block turns logical page numbers from a host into physical page numbers of a small NAND array that sits inside the block. The table holds one entry per logical page. Every physical page carries a state of free, valid or stale, and every erase block keeps a wear counter.

A read is a lookup in the table and starts no flash operation. A write never updates a page in place. It takes the next erased page of the active block and programs it. It then marks the page that held the old copy as stale and points the table entry at the new page. Erasing happens only for a whole block. When no erased page is left, a block whose pages are all stale is erased and reused. If no such block exists either, the write is refused.

The host port is a valid/ready handshake with a one-cycle response strobe. Ready stays low while a program or erase is running. The flash command port shows each operation to the array model inside the block.

Top module: `flash_xlate_ctl`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `rsp_valid` is 0 and `fl_op` is 0 (idle). Every logical page is unmapped, every physical page is free, every block's wear count is 0, and the active block is block 0 at offset 0.
- R2: A read of a mapped logical page raises `rsp_valid` one cycle after it is accepted. It returns the mapped physical page in `rsp_ppn` with both flags at 0, and `fl_op` stays 0 throughout.
- R3: A read of a logical page that has never been written responds one cycle after acceptance with `rsp_unmapped`=1, `rsp_full`=0 and `rsp_ppn`=0. `rsp_unmapped` and `rsp_full` are never 1 in the same response.
- R4: A write takes the next page of the active block, which is physical page block*PAGES_PER_BLK+offset. `fl_op` shows 1 (program) for PROG_CYC cycles with `fl_ppn` held at that page. The response with that page number follows PROG_CYC+1 cycles after acceptance.
- R5: When the active block has no pages left, a write opens the first fully erased block in round-robin order, starting at the block after the active one, and programs its page 0.
- R6: Overwriting a logical page changes only that page's entry. A later read returns the new physical page, and other logical pages keep their mapping.
- R7: When no erased page is left, the write erases the first fully stale block in round-robin order, starting after the active block. `fl_op` shows 2 (erase) for ERASE_CYC cycles with `fl_ppn` at the block's page 0, followed by a program of that page 0. The block's wear count rises by 1, and the response follows ERASE_CYC+PROG_CYC+1 cycles after acceptance.
- R8: When there is no erased page and no fully stale block, the write responds one cycle after acceptance with `rsp_full`=1 and `rsp_ppn`=0. The table is left unchanged.
- R9: `req_ready` is 0 on every cycle in which a program or erase is running, and 1 otherwise.
- R10: No page is programmed twice without an erase of its block in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_lpn | input | LPW | Logical page number |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_ppn | output | PPW | Physical page returned |
| rsp_unmapped | output | 1 | Read hit a never-written page |
| rsp_full | output | 1 | Write refused, no space can be reclaimed |
| fl_op | output | 2 | Flash operation: 0 idle, 1 program, 2 erase |
| fl_ppn | output | PPW | Page being programmed, or page 0 of the block being erased |
| wear_blk | input | BW | Block selected for wear readout |
| wear_cnt | output | ECW | Erase count of the selected block |

## Verification
With the default parameters, a read or a refused write responds one cycle after the accepting edge. A plain write responds PROG_CYC+1 = 4 cycles after acceptance, and a write that first reclaims a block responds ERASE_CYC+PROG_CYC+1 = 9 cycles after. The bench drives inputs and samples outputs on falling edges. Starting at the accepting edge, it counts cycles until the strobe appears, and it also counts the cycles that show program, erase and ready low. Each count is compared with the figure a reference model predicts for that request's allocation path. The wear counts are read through the readout port after the combinational path has settled.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

    typedef enum logic [1:0] {
        PG_FREE  = 2'd0,
        PG_VALID = 2'd1,
        PG_STALE = 2'd2
    } pg_state_e;

    typedef enum logic [1:0] {
        FOP_IDLE  = 2'd0,
        FOP_PROG  = 2'd1,
        FOP_ERASE = 2'd2
    } fop_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_PROG  = 2'd2
    } ctl_state_e;

    function automatic int unsigned bits_for(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ftl_map_table.sv
module ftl_map_table
    import ftl_pkg::*;
#(
    parameter int LPAGES = 8,
    parameter int LPW    = 3,
    parameter int PPW    = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [LPW-1:0] rd_lpn,
    output logic           rd_hit,
    output logic [PPW-1:0] rd_ppn,
    input  logic           wr_en,
    input  logic [LPW-1:0] wr_lpn,
    input  logic [PPW-1:0] wr_ppn
);
    logic [PPW-1:0]    entry [LPAGES];
    logic [LPAGES-1:0] mapped;

    always_ff @(posedge clk) begin
        if (rst) begin
            mapped <= '0;
            for (int i = 0; i < LPAGES; i++) entry[i] <= '0;
        end else if (wr_en) begin
            mapped[wr_lpn] <= 1'b1;
            entry[wr_lpn]  <= wr_ppn;
        end
    end

    assign rd_hit = mapped[rd_lpn];
    assign rd_ppn = entry[rd_lpn];
endmodule

// File: rtl/ftl_block_pick.sv
module ftl_block_pick
    import ftl_pkg::*;
#(
    parameter int BLOCKS = 4,
    parameter int PPB    = 4,
    parameter int BW     = 2
) (
    input  pg_state_e       pst [BLOCKS*PPB],
    input  logic [BW-1:0]   act_blk,
    output logic            free_ok,
    output logic [BW-1:0]   free_blk,
    output logic            stale_ok,
    output logic [BW-1:0]   stale_blk
);
    logic [BLOCKS-1:0] all_free;
    logic [BLOCKS-1:0] all_stale;

    for (genvar g = 0; g < BLOCKS; g++) begin : g_blk
        always_comb begin
            all_free[g]  = 1'b1;
            all_stale[g] = 1'b1;
            for (int p = 0; p < PPB; p++) begin
                if (pst[g*PPB+p] != PG_FREE)  all_free[g]  = 1'b0;
                if (pst[g*PPB+p] != PG_STALE) all_stale[g] = 1'b0;
            end
        end
    end

    // round-robin: walk from the farthest candidate back to the nearest,
    // so the nearest block after the active one wins
    always_comb begin
        free_ok   = 1'b0;
        free_blk  = '0;
        stale_ok  = 1'b0;
        stale_blk = '0;
        for (int i = BLOCKS; i >= 1; i--) begin
            int b;
            b = (int'(act_blk) + i) % BLOCKS;
            if (all_free[b]) begin
                free_ok  = 1'b1;
                free_blk = BW'(b);
            end
            if (all_stale[b]) begin
                stale_ok  = 1'b1;
                stale_blk = BW'(b);
            end
        end
    end
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
    import ftl_pkg::*;
#(
    parameter int BLOCKS = 4,
    parameter int PPB    = 4,
    parameter int PPW    = 4,
    parameter int BW     = 2,
    parameter int ECW    = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     fl_op,
    input  logic [PPW-1:0] fl_ppn,
    input  logic [BW-1:0]  wear_blk,
    output logic [ECW-1:0] wear_cnt,
    output logic           dirty_hit
);
    localparam int NPAGES = BLOCKS * PPB;

    logic [1:0]        prev_op;
    logic [NPAGES-1:0] written;
    logic [ECW-1:0]    wear [BLOCKS];
    logic [BW-1:0]     op_blk;
    logic              prog_start;
    logic              erase_start;

    assign op_blk      = BW'(int'(fl_ppn) / PPB);
    assign prog_start  = (fl_op == FOP_PROG)  && (prev_op != FOP_PROG);
    assign erase_start = (fl_op == FOP_ERASE) && (prev_op != FOP_ERASE);
    assign dirty_hit   = prog_start && written[fl_ppn];
    assign wear_cnt    = wear[wear_blk];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_op <= FOP_IDLE;
            written <= '0;
            for (int b = 0; b < BLOCKS; b++) wear[b] <= '0;
        end else begin
            prev_op <= fl_op;
            if (prog_start) written[fl_ppn] <= 1'b1;
            if (erase_start) begin
                wear[op_blk] <= wear[op_blk] + 1'b1;
                for (int p = 0; p < NPAGES; p++)
                    if (p / PPB == int'(op_blk)) written[p] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/flash_xlate_ctl.sv
module flash_xlate_ctl
    import ftl_pkg::*;
#(
    parameter int LPAGES    = 8,
    parameter int BLOCKS    = 4,
    parameter int PPB       = 4,
    parameter int PROG_CYC  = 3,
    parameter int ERASE_CYC = 5,
    parameter int ECW       = 8,
    localparam int NPAGES   = BLOCKS * PPB,
    localparam int LPW      = bits_for(LPAGES),
    localparam int PPW      = bits_for(NPAGES),
    localparam int BW       = bits_for(BLOCKS),
    localparam int OW       = bits_for(PPB + 1),
    localparam int CW       = bits_for((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_write,
    input  logic [LPW-1:0] req_lpn,
    output logic           rsp_valid,
    output logic [PPW-1:0] rsp_ppn,
    output logic           rsp_unmapped,
    output logic           rsp_full,
    output logic [1:0]     fl_op,
    output logic [PPW-1:0] fl_ppn,
    input  logic [BW-1:0]  wear_blk,
    output logic [ECW-1:0] wear_cnt
);
    ctl_state_e     st;
    logic [CW-1:0]  cnt;
    logic [LPW-1:0] cur_lpn;
    logic [PPW-1:0] tgt;
    logic [BW-1:0]  ers_blk;
    logic [BW-1:0]  act_blk;
    logic [OW-1:0]  act_off;
    pg_state_e      pst [NPAGES];

    logic           accept;
    logic           room;
    logic [LPW-1:0] rd_lpn;
    logic           rd_hit;
    logic [PPW-1:0] rd_ppn;
    logic           map_we;
    logic           free_ok, stale_ok;
    logic [BW-1:0]  free_blk, stale_blk;
    logic           dirty_hit;

    function automatic logic [PPW-1:0] page_of(input logic [BW-1:0] b, input int o);
        return PPW'(int'(b) * PPB + o);
    endfunction

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign room      = int'(act_off) < PPB;
    assign rd_lpn    = (st == ST_IDLE) ? req_lpn : cur_lpn;
    assign map_we    = (st == ST_PROG) && (cnt == '0);

    always_comb begin
        unique case (st)
            ST_PROG:  begin fl_op = FOP_PROG;  fl_ppn = tgt; end
            ST_ERASE: begin fl_op = FOP_ERASE; fl_ppn = page_of(ers_blk, 0); end
            default:  begin fl_op = FOP_IDLE;  fl_ppn = '0; end
        endcase
    end

    ftl_map_table #(.LPAGES(LPAGES), .LPW(LPW), .PPW(PPW)) u_map (
        .clk    (clk),
        .rst    (rst),
        .rd_lpn (rd_lpn),
        .rd_hit (rd_hit),
        .rd_ppn (rd_ppn),
        .wr_en  (map_we),
        .wr_lpn (cur_lpn),
        .wr_ppn (tgt)
    );

    ftl_block_pick #(.BLOCKS(BLOCKS), .PPB(PPB), .BW(BW)) u_pick (
        .pst       (pst),
        .act_blk   (act_blk),
        .free_ok   (free_ok),
        .free_blk  (free_blk),
        .stale_ok  (stale_ok),
        .stale_blk (stale_blk)
    );

    flash_array_model #(.BLOCKS(BLOCKS), .PPB(PPB), .PPW(PPW), .BW(BW), .ECW(ECW)) u_array (
        .clk       (clk),
        .rst       (rst),
        .fl_op     (fl_op),
        .fl_ppn    (fl_ppn),
        .wear_blk  (wear_blk),
        .wear_cnt  (wear_cnt),
        .dirty_hit (dirty_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            cnt          <= '0;
            cur_lpn      <= '0;
            tgt          <= '0;
            ers_blk      <= '0;
            act_blk      <= '0;
            act_off      <= '0;
            rsp_valid    <= 1'b0;
            rsp_ppn      <= '0;
            rsp_unmapped <= 1'b0;
            rsp_full     <= 1'b0;
            for (int p = 0; p < NPAGES; p++) pst[p] <= PG_FREE;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        cur_lpn <= req_lpn;
                        if (!req_write) begin
                            rsp_valid    <= 1'b1;
                            rsp_unmapped <= !rd_hit;
                            rsp_full     <= 1'b0;
                            rsp_ppn      <= rd_hit ? rd_ppn : '0;
                        end else if (room) begin
                            tgt     <= page_of(act_blk, int'(act_off));
                            act_off <= act_off + 1'b1;
                            cnt     <= CW'(PROG_CYC - 1);
                            st      <= ST_PROG;
                        end else if (free_ok) begin
                            tgt     <= page_of(free_blk, 0);
                            act_blk <= free_blk;
                            act_off <= OW'(1);
                            cnt     <= CW'(PROG_CYC - 1);
                            st      <= ST_PROG;
                        end else if (stale_ok) begin
                            ers_blk <= stale_blk;
                            cnt     <= CW'(ERASE_CYC - 1);
                            st      <= ST_ERASE;
                        end else begin
                            rsp_valid    <= 1'b1;
                            rsp_unmapped <= 1'b0;
                            rsp_full     <= 1'b1;
                            rsp_ppn      <= '0;
                        end
                    end
                end
                ST_ERASE: begin
                    if (cnt == '0) begin
                        for (int p = 0; p < NPAGES; p++)
                            if (p / PPB == int'(ers_blk)) pst[p] <= PG_FREE;
                        act_blk <= ers_blk;
                        act_off <= OW'(1);
                        tgt     <= page_of(ers_blk, 0);
                        cnt     <= CW'(PROG_CYC - 1);
                        st      <= ST_PROG;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_PROG: begin
                    if (cnt == '0) begin
                        pst[tgt] <= PG_VALID;
                        if (rd_hit) pst[rd_ppn] <= PG_STALE;
                        rsp_valid    <= 1'b1;
                        rsp_ppn      <= tgt;
                        rsp_unmapped <= 1'b0;
                        rsp_full     <= 1'b0;
                        st           <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_xlate_chk.sv
module flash_xlate_chk #(
    parameter int PPW = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           req_ready,
    input logic           rsp_valid,
    input logic           rsp_unmapped,
    input logic           rsp_full,
    input logic [1:0]     fl_op,
    input logic [PPW-1:0] fl_ppn,
    input logic           dirty_hit
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && fl_op == 2'd0));

    // R9
    busy_noready_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_op != 2'd0) |-> !req_ready);

    // R3
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_unmapped && rsp_full));

    // R4
    prog_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_op == 2'd1 && $past(fl_op) == 2'd1) |-> $stable(fl_ppn));

    // R7
    erase_then_prog_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_op == 2'd2) |=> (fl_op == 2'd2 || fl_op == 2'd1));

    // R10
    no_reprogram_chk: assert property (@(posedge clk) disable iff (rst)
        !dirty_hit);
endmodule

bind flash_xlate_ctl flash_xlate_chk #(.PPW(PPW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_unmapped (rsp_unmapped),
    .rsp_full     (rsp_full),
    .fl_op        (fl_op),
    .fl_ppn       (fl_ppn),
    .dirty_hit    (dirty_hit)
);

// File: tb/flash_xlate_ctl_test.sv
`timescale 1ns/1ps
module flash_xlate_ctl_test;
    localparam int LP = 8, NB = 4, PB = 4, PC = 3, EC = 5;
    localparam int NP = NB * PB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [2:0] req_lpn = '0;
    logic       rsp_valid;
    logic [3:0] rsp_ppn;
    logic       rsp_unmapped;
    logic       rsp_full;
    logic [1:0] fl_op;
    logic [3:0] fl_ppn;
    logic [1:0] wear_blk = '0;
    logic [7:0] wear_cnt;

    always #5 clk = ~clk;

    flash_xlate_ctl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_lpn(req_lpn), .rsp_valid(rsp_valid),
        .rsp_ppn(rsp_ppn), .rsp_unmapped(rsp_unmapped), .rsp_full(rsp_full),
        .fl_op(fl_op), .fl_ppn(fl_ppn), .wear_blk(wear_blk), .wear_cnt(wear_cnt)
    );

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    // reference model: 0 free, 1 valid, 2 stale
    int m_map [LP];
    bit m_vld [LP];
    int m_pst [NP];
    int m_wear [NB];
    int m_blk, m_off;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: got %0d cycles exp below 150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < LP; i++) begin m_map[i] = 0; m_vld[i] = 0; end
        for (int i = 0; i < NP; i++) m_pst[i] = 0;
        for (int i = 0; i < NB; i++) m_wear[i] = 0;
        m_blk = 0; m_off = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
    endtask

    task automatic run_req(input bit wr, input int lpn, output int lat, output int pc,
                           output int ecn, output int rlo);
        req_valid = 1'b1; req_write = wr; req_lpn = 3'(lpn);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; pc = 0; ecn = 0; rlo = 0;
        while (!rsp_valid && lat < 100) begin
            if (fl_op == 2'd1) pc++;
            if (fl_op == 2'd2) ecn++;
            if (!req_ready) rlo++;
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic bool_blk_all(input int b, input int s);
        for (int p = 0; p < PB; p++) if (m_pst[b*PB+p] != s) return 0;
        return 1;
    endfunction

    task automatic do_read(input int lpn);
        int lat, pc, ecn, rlo;
        run_req(0, lpn, lat, pc, ecn, rlo);
        chk(lat == 1, "R2 read latency", lat, 1);
        chk(pc == 0 && ecn == 0, "R2 read flash idle", pc + ecn, 0);
        if (m_vld[lpn]) begin
            chk(rsp_ppn == m_map[lpn] && !rsp_unmapped && !rsp_full,
                "R2 R6 read ppn", int'(rsp_ppn), m_map[lpn]);
        end else begin
            chk(rsp_unmapped && !rsp_full && rsp_ppn == 0,
                "R3 unmapped flag", int'(rsp_unmapped), 1);
        end
    endtask

    task automatic do_write(input int lpn);
        int lat, pc, ecn, rlo;
        int e_ppn, e_lat, e_pc, e_ec, fb, sb;
        bit full;
        string tag;
        full = 0; e_ec = 0; e_pc = PC; fb = -1; sb = -1;
        if (m_off < PB) begin
            e_ppn = m_blk * PB + m_off; m_off++; tag = "R4 write";
        end else begin
            for (int i = NB; i >= 1; i--) begin
                int b;
                b = (m_blk + i) % NB;
                if (bool_blk_all(b, 0)) fb = b;
                if (bool_blk_all(b, 2)) sb = b;
            end
            if (fb >= 0) begin
                m_blk = fb; m_off = 1; e_ppn = fb * PB; tag = "R5 next block";
            end else if (sb >= 0) begin
                m_wear[sb]++;
                for (int p = 0; p < PB; p++) m_pst[sb*PB+p] = 0;
                m_blk = sb; m_off = 1; e_ppn = sb * PB; e_ec = EC; tag = "R7 reclaim";
            end else begin
                full = 1; e_ppn = 0; e_pc = 0; tag = "R8 full";
            end
        end
        e_lat = full ? 1 : e_ec + e_pc + 1;
        run_req(1, lpn, lat, pc, ecn, rlo);
        chk(lat == e_lat, {tag, " latency"}, lat, e_lat);
        chk(pc == e_pc && ecn == e_ec, {tag, " R9 flash cycles"}, pc * 100 + ecn, e_pc * 100 + e_ec);
        chk(rlo == e_pc + e_ec, {tag, " R9 ready low"}, rlo, e_pc + e_ec);
        chk(rsp_ppn == e_ppn && rsp_full == full && !rsp_unmapped, {tag, " ppn"},
            int'(rsp_ppn), e_ppn);
        if (!full) begin
            if (m_vld[lpn]) m_pst[m_map[lpn]] = 2;
            m_pst[e_ppn] = 1;
            m_map[lpn] = e_ppn;
            m_vld[lpn] = 1;
        end
    endtask

    task automatic check_wear();
        for (int b = 0; b < NB; b++) begin
            wear_blk = 2'(b);
            #1;
            chk(wear_cnt == m_wear[b], "R7 wear count", int'(wear_cnt), m_wear[b]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(fl_op == 2'd0, "R1 fl_op", int'(fl_op), 0);
        check_wear();
        for (int l = 0; l < LP; l++) do_read(l);   // R3 all unmapped

        // R4 R6 overwrite
        do_write(3); do_write(3); do_read(3);
        do_write(4); do_read(4); do_read(3);

        // R7 reclaim of a fully stale block
        do_reset();
        for (int k = 0; k < 17; k++) do_write(0);
        check_wear();
        do_read(0);

        // R5 block switch, then R8 full with no reclaimable block
        do_reset();
        for (int l = 0; l < LP; l++) do_write(l);
        do_write(0); do_write(4); do_write(1); do_write(5);
        do_write(2); do_write(2); do_write(6); do_write(6);
        do_write(3);
        for (int l = 0; l < LP; l++) do_read(l);   // R8 table unchanged

        // random mix
        do_reset();
        for (int n = 0; n < 600; n++) begin
            int l;
            l = int'($urandom_range(LP - 1, 0));
            if ($urandom_range(1, 0) == 1) do_write(l);
            else do_read(l);
            if (n % 50 == 49) check_wear();
        end
        check_wear();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule